// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Control

This block holds the per-CPU interrupt state for a system of up to four processors. Software raises and retires interprocessor interrupts by writing one 64-bit control word. The same word also acknowledges periodic timer interrupts. Each field of the word acts on one CPU per bit.

A timer tick input latches a timer interrupt for every CPU counted as present. Each CPU gets two level outputs: one for interprocessor interrupts and one for the timer.

A read returns the latched state, with the ID of the reading CPU merged into the two lowest bits. Accesses narrower than 64 bits are refused. Writes that touch no recognised field are refused too. A refused access raises an error pulse and leaves the state as it was.

Top module: `ipi_timer_ctl`

## Requirements
- R1: After reset, `ipi_irq`, `tmr_irq` and `err` are all zero, and a read returns only the requester ID.
- R2: On a legal write, a 1 in bit 12+n sets CPU n's pending IPI and raises `ipi_irq[n]` after the clock edge. Bit 12 selects CPU 0. A request for a CPU whose IPI is already pending changes nothing.
- R3: On a legal write, a 1 in bit 8+n clears CPU n's pending IPI and lowers `ipi_irq[n]` after the clock edge. For a CPU with no pending IPI it has no effect.
- R4: When one write sets both bit 12+n and bit 8+n, the post is applied first and the clear second, so CPU n's IPI ends cleared.
- R5: A cycle with `tick` high raises `tmr_irq[n]` after the clock edge for each CPU n with n < `cpu_count`. The timer lines of CPUs with n >= `cpu_count` are left unchanged.
- R6: On a legal write, a 1 in bit 4+n clears CPU n's timer status and lowers `tmr_irq[n]` after the clock edge.
- R7: When a tick and a timer clear for the same CPU fall in the same cycle, the clear is applied first and the tick second, so the timer line ends high.
- R8: While `rd_en` is high, `rdata` gives:
  - the pending IPIs in bits 11:8;
  - the timer status in bits 7:4;
  - `req_id` in bits 1:0;
  - zeros in all other bits.

  The value is combinational, taken in the same cycle.
- R9: A legal write with bit 28 set and none of bits 15:4 set is accepted: `err` stays low and no state changes.
- R10: A legal-size write with none of bits 15:4 and not bit 28 set is refused. It pulses `err` in the next cycle and leaves the state unchanged.
- R11: An access with `acc_size` other than 3 is refused, for reads and writes alike. The `acc_size` encoding is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. A refused access pulses `err` in the next cycle and leaves the IPI and timer state unchanged.
- R12: `err` is high for exactly one cycle per refused access. It is never high after a cycle with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| rd_en | input | 1 | Read strobe for the control word |
| acc_size | input | 2 | Access size, log2 of bytes; only 3 is legal |
| wdata | input | 64 | Write data |
| req_id | input | 2 | ID of the CPU making the access |
| rdata | output | 64 | Read data, valid while `rd_en` is high |
| tick | input | 1 | Periodic timer tick |
| cpu_count | input | 3 | Number of present CPUs (0 to 4) |
| ipi_irq | output | 4 | Interprocessor interrupt line per CPU |
| tmr_irq | output | 4 | Timer interrupt line per CPU |
| err | output | 1 | Refused-access pulse |

## Verification
The interrupt lines and `err` are each one register behind their stimulus. The bench therefore drives every access and tick at a falling edge and compares those outputs at the next falling edge, after exactly one rising edge. `rdata` has no register in its path, so it is compared one time step after the inputs settle, before the edge that applies the same access. A bench model of the pending and status bits is advanced once per cycle, only after both comparisons. Each comparison therefore sees the state before or after exactly one update.

// File: rtl/ipi_timer_ctl.sv
module ipi_timer_ctl #(
  parameter int NCPU = 4,
  parameter int DW   = 64,
  parameter int IDW  = 2,
  parameter int CW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [1:0]      acc_size,
  input  logic [DW-1:0]   wdata,
  input  logic [IDW-1:0]  req_id,
  output logic [DW-1:0]   rdata,
  input  logic            tick,
  input  logic [CW-1:0]   cpu_count,
  output logic [NCPU-1:0] ipi_irq,
  output logic [NCPU-1:0] tmr_irq,
  output logic            err
);
  localparam int F_TCLR  = 4;
  localparam int F_PEND  = 8;
  localparam int F_POST  = 12;
  localparam int F_IGN   = 28;
  localparam int F_TOP   = F_POST + NCPU - 1;
  localparam logic [1:0] SZ_FULL = 2'd3;

  logic [NCPU-1:0] pend_q, stat_q, present;
  logic            err_q;

  wire full   = (acc_size == SZ_FULL);
  wire acc    = wr_en | rd_en;
  wire wr_ok  = wr_en & full;
  wire known  = (|wdata[F_TOP:F_TCLR]) | wdata[F_IGN];

  wire [NCPU-1:0] post = wr_ok ? wdata[F_POST +: NCPU] : '0;
  wire [NCPU-1:0] iclr = wr_ok ? wdata[F_PEND +: NCPU] : '0;
  wire [NCPU-1:0] tclr = wr_ok ? wdata[F_TCLR +: NCPU] : '0;
  wire [NCPU-1:0] tset = tick ? present : '0;

  for (genvar n = 0; n < NCPU; n++) begin : g_present
    assign present[n] = (32'(cpu_count) > n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      stat_q <= '0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q | post) & ~iclr;
      stat_q <= (stat_q & ~tclr) | tset;
      err_q  <= (acc & ~full) | (wr_ok & ~known);
    end
  end

  always_comb begin
    rdata = '0;
    rdata[F_PEND +: NCPU] = pend_q;
    rdata[F_TCLR +: NCPU] = stat_q;
    rdata[IDW-1:0]        = req_id;
  end

  assign ipi_irq = pend_q;
  assign tmr_irq = stat_q;
  assign err     = err_q;

  a_r2_ipi_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ipi_irq & ~$past(ipi_irq))) |-> ($past(wr_en) && $past(acc_size) == SZ_FULL));

  a_r5_tmr_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tmr_irq & ~$past(tmr_irq))) |-> $past(tick));

  a_r6_tmr_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~tmr_irq & $past(tmr_irq))) |-> ($past(wr_en) && $past(acc_size) == SZ_FULL));

  a_r11_narrow_keeps_ipi: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && acc_size != SZ_FULL) |=> ($stable(ipi_irq) && err));

  a_r12_err_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(acc));
endmodule

// File: tb/test_ipi_timer_ctl.sv
module test_ipi_timer_ctl;
  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, tick = 0;
  logic [1:0]  acc_size = 2'd3, req_id = 0;
  logic [63:0] wdata = 0, rdata;
  logic [2:0]  cpu_count = 3'd4;
  logic [3:0]  ipi_irq, tmr_irq;
  logic        err;
  int total = 0, bad = 0;
  logic [3:0]  m_pend = 0, m_stat = 0;

  always #2.5 clk = ~clk;

  ipi_timer_ctl i_ipi_timer_ctl (.clk, .rst_n, .wr_en, .rd_en, .acc_size, .wdata,
    .req_id, .rdata, .tick, .cpu_count, .ipi_irq, .tmr_irq, .err);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pres(logic [2:0] c);
    logic [3:0] p;
    for (int n = 0; n < 4; n++) p[n] = (n < c);
    return p;
  endfunction

  function automatic logic [63:0] exp_read(logic [3:0] p, logic [3:0] s, logic [1:0] id);
    return (64'(p) << 8) | (64'(s) << 4) | 64'(id);
  endfunction

  task automatic cyc(string req, logic w, logic r, logic [1:0] sz, logic [63:0] wd,
                     logic [1:0] id, logic tk, logic [2:0] cnt);
    logic ok, known, e_err;
    logic [3:0] np, ns;
    wr_en = w; rd_en = r; acc_size = sz; wdata = wd; req_id = id; tick = tk; cpu_count = cnt;
    #1;
    if (r) chk({req, " R8 read"}, rdata, exp_read(m_pend, m_stat, id));
    ok    = w && sz == 2'd3;
    known = (|wd[15:4]) || wd[28];
    e_err = ((w || r) && sz != 2'd3) || (ok && !known);
    np = m_pend; ns = m_stat;
    if (ok) begin
      np = (np | wd[15:12]) & ~wd[11:8];
      ns = ns & ~wd[7:4];
    end
    if (tk) ns = ns | pres(cnt);
    @(negedge clk);
    m_pend = np; m_stat = ns;
    chk({req, " ipi"}, 64'(ipi_irq), 64'(np));
    chk({req, " tmr"}, 64'(tmr_irq), 64'(ns));
    chk({req, " R12 err"}, 64'(err), 64'(e_err));
    wr_en = 0; rd_en = 0; tick = 0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_en = 1; req_id = 2'd2; #1;
    chk("R1 ipi", 64'(ipi_irq), 0); chk("R1 tmr", 64'(tmr_irq), 0);
    chk("R1 err", 64'(err), 0);     chk("R1 read", rdata, 64'h2);
    rd_en = 0;
    @(negedge clk);
    cyc("R2 post cpu0,2", 1, 0, 3, 64'h5000, 0, 0, 4);
    cyc("R2 repeat post", 1, 0, 3, 64'h1000, 1, 0, 4);
    cyc("R8 read pend",   0, 1, 3, 0, 3, 0, 4);
    cyc("R3 clear cpu2",  1, 0, 3, 64'h0400, 0, 0, 4);
    cyc("R3 clear idle",  1, 0, 3, 64'h0800, 0, 0, 4);
    cyc("R4 post+clear",  1, 0, 3, 64'h2200, 0, 0, 4);
    chk("R4 cpu1 cleared", 64'(ipi_irq[1]), 0);
    cyc("R5 tick cnt2",   0, 0, 3, 0, 0, 1, 2);
    chk("R5 absent cpu3 low", 64'(tmr_irq[3]), 0);
    cyc("R5 tick cnt4",   0, 0, 3, 0, 0, 1, 4);
    cyc("R6 tclr cpu0",   1, 0, 3, 64'h0010, 0, 0, 4);
    cyc("R7 tick+tclr",   1, 0, 3, 64'h0020, 0, 1, 4);
    chk("R7 cpu1 timer high", 64'(tmr_irq[1]), 1);
    cyc("R9 bit28 only",  1, 0, 3, 64'h1000_0000, 0, 0, 4);
    cyc("R10 unknown wr", 1, 0, 3, 64'h8000_0000_0000_0001, 0, 0, 4);
    cyc("R11 narrow wr",  1, 0, 2, 64'h0000_F0F0, 0, 0, 4);
    cyc("R11 narrow rd",  0, 1, 0, 0, 1, 0, 4);
    cyc("R12 idle",       0, 0, 3, 0, 0, 0, 4);
    for (int k = 0; k < 400; k++) begin
      logic [63:0] wd;
      logic [2:0] a;
      wd = {32'($urandom), 32'($urandom)} & 64'h9000_0000_1000_FFF3;
      if ($urandom % 6 == 0) wd[15:4] = 0;
      a = 3'($urandom % 5);
      cyc("random", a inside {[0:2]}, a == 3, ($urandom % 5 == 0) ? 2'($urandom) : 2'd3,
          wd, 2'($urandom), ($urandom % 4 == 0), 3'($urandom % 5));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule